// File: doc/BRIEF.md
# Phase-Cut Dimmer Type Classifier

This block decides what kind of mains switch sits in front of a lamp driver: a plain switch with no dimmer, a dimmer that cuts the front of each half cycle (leading-edge), or a dimmer that cuts the back of each half cycle (trailing-edge). It then reports the matching operating mode. It is fed one digitised sample of the rectified line on every tick where `line_vld` is high. A strobe, `zc_stb`, marks the end of each half cycle. Within a half cycle it tracks the steepest rise and the steepest fall between consecutive samples. It also counts how many samples are above a small zero threshold (the conduction time) and how many samples arrived in total (the period).

At each strobe the half cycle gets a verdict. Equal verdicts must repeat over several half cycles in a row before the reported mode changes. After a mode is committed, learning pauses for a fixed number of half cycles and then starts again, so a change of dimmer while the lamp runs is picked up. Until the first commit after reset, the block reports leading-edge mode with the valid flag low. At every strobe it also outputs the conduction time as an 8-bit fraction of the period. A later stage uses this value as the dim level.

If a sample arrives in the same cycle as the strobe, it updates the slope reference but is not counted in either half cycle.

Top module: `dimmer_classifier`

## Requirements
- R1: `mode` uses 2'b00 for no dimmer, 2'b01 for leading-edge and 2'b10 for trailing-edge. 2'b11 never appears.
- R2: During reset and after it, `mode` is 2'b01, `mode_vld` is 0 and `cond_angle` is 0. `mode_vld` rises at the first commit and then stays 1 until the next reset.
- R3: A half cycle whose largest sample-to-sample rise is at least `STEEP_THR` gets a leading-edge verdict. This holds even if it also has a steep fall.
- R4: A half cycle with no steep rise whose largest sample-to-sample fall is at least `STEEP_THR` gets a trailing-edge verdict.
- R5: A half cycle with no steep edge gets a no-dimmer verdict when conduction samples × 16 ≥ period × `FULL_NUM`.
- R6: Any other half cycle, including one with no samples or no conduction, gets no verdict and breaks the current run of equal verdicts.
- R7: While learning, `mode` takes a verdict at the strobe that ends the `CONFIRM_N`-th (default 4) consecutive equal verdict. A different verdict in between restarts the count.
- R8: After a commit, learning pauses and `mode` holds whatever the line does. The `RELEARN_HC`-th (default 64) strobe after the commit restarts learning, and verdicts count from the half cycle that follows it.
- R9: At every strobe, `cond_angle` becomes floor(256 × conduction / period). Conduction counts samples above `ZERO_THR`. The result saturates at 255 and is 0 for a period of zero. It updates whether learning is active or not.
- R10: `mode`, `mode_vld` and `cond_angle` change only in the cycle after a strobe or a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| line_vld | input | 1 | A new line sample is present this cycle |
| line_smp | input | SMP_W | Rectified line sample, unsigned |
| zc_stb | input | 1 | End of the current half cycle |
| mode | output | 2 | Selected operating mode (R1 encoding) |
| mode_vld | output | 1 | A classification has completed since reset |
| cond_angle | output | 8 | Conduction time as a fraction of the period, ×256 |

## Verification
The bench first checks that the first three matching half cycles leave the reset mode in place and that the fourth commits. A filter that counted one half cycle short or long would change mode a strobe early or late. During the pause it feeds a new dimmer type and samples the mode at strobes 63, 64, 67 and 68 after the commit. A design that resumed learning one strobe off, or that ignored the pause, would show the new mode at the wrong strobe. It inserts a single different verdict and a dead half cycle into a run, which a design that failed to clear the run would commit too early. It also drives a waveform with both a steep rise and a steep fall to check priority, and a fully conducting half cycle to check that the angle saturates instead of wrapping to 0.

// File: rtl/dimclass_pkg.sv
package dimclass_pkg;

    typedef enum logic [1:0] {
        SW_NONE  = 2'b00,
        SW_LEAD  = 2'b01,
        SW_TRAIL = 2'b10
    } sw_mode_e;

    localparam int ANG_W     = 8;
    localparam int FRAC_IN_W = 16;

    // per-half-cycle measurements, zero-extended to a common width
    typedef struct packed {
        logic [FRAC_IN_W-1:0] rise;
        logic [FRAC_IN_W-1:0] fall;
        logic [FRAC_IN_W-1:0] cond;
        logic [FRAC_IN_W-1:0] per;
    } hc_meas_t;

    typedef struct packed {
        logic     ok;
        sw_mode_e kind;
    } verdict_t;

    // floor(2^ANG_W * part / whole), saturated, restoring division
    function automatic logic [ANG_W-1:0] angle_frac(input logic [FRAC_IN_W-1:0] part,
                                                   input logic [FRAC_IN_W-1:0] whole);
        logic [FRAC_IN_W:0] rem;
        logic [ANG_W-1:0]   q;
        q   = '0;
        rem = {1'b0, part};
        if (whole == '0) return '0;
        if (part >= whole) return '1;
        for (int b = ANG_W - 1; b >= 0; b--) begin
            rem = rem << 1;
            if (rem >= {1'b0, whole}) begin
                rem  = rem - {1'b0, whole};
                q[b] = 1'b1;
            end
        end
        return q;
    endfunction

endpackage

// File: rtl/dc_edge_meter.sv
module dc_edge_meter
    import dimclass_pkg::*;
#(
    parameter int SMP_W    = 10,
    parameter int CNT_W    = 12,
    parameter int ZERO_THR = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             smp_vld,
    input  logic [SMP_W-1:0] smp,
    input  logic             hc_end,
    output hc_meas_t         meas
);

    logic [SMP_W-1:0] prev_q, rise_q, fall_q;
    logic [CNT_W-1:0] cond_q, per_q;
    logic [SMP_W-1:0] rise_now, fall_now;
    logic             above_zero;

    always_comb begin
        rise_now   = (smp > prev_q) ? (smp - prev_q) : '0;
        fall_now   = (prev_q > smp) ? (prev_q - smp) : '0;
        above_zero = (smp > SMP_W'(ZERO_THR));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            rise_q <= '0;
            fall_q <= '0;
            cond_q <= '0;
            per_q  <= '0;
        end else begin
            if (smp_vld) prev_q <= smp;
            if (hc_end) begin
                rise_q <= '0;
                fall_q <= '0;
                cond_q <= '0;
                per_q  <= '0;
            end else if (smp_vld) begin
                if (rise_now > rise_q) rise_q <= rise_now;
                if (fall_now > fall_q) fall_q <= fall_now;
                if (per_q != '1) per_q <= per_q + 1'b1;
                if (above_zero && cond_q != '1) cond_q <= cond_q + 1'b1;
            end
        end
    end

    always_comb begin
        meas.rise = FRAC_IN_W'(rise_q);
        meas.fall = FRAC_IN_W'(fall_q);
        meas.cond = FRAC_IN_W'(cond_q);
        meas.per  = FRAC_IN_W'(per_q);
    end

endmodule

// File: rtl/dc_mode_filter.sv
module dc_mode_filter
    import dimclass_pkg::*;
#(
    parameter int STEEP_THR  = 200,
    parameter int FULL_NUM   = 14,
    parameter int CONFIRM_N  = 4,
    parameter int RELEARN_HC = 64
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     hc_end,
    input  hc_meas_t meas,
    output sw_mode_e mode,
    output logic     mode_vld
);

    localparam int STRK_W = $clog2(CONFIRM_N + 1);
    localparam int IDLE_W = $clog2(RELEARN_HC + 1);
    localparam int SC_W   = FRAC_IN_W + 5;

    verdict_t          vd;
    logic              learn_q;
    sw_mode_e          cand_q;
    logic [STRK_W-1:0] streak_q, run_len;
    logic [IDLE_W-1:0] idle_q;
    logic [SC_W-1:0]   cond_sc, per_sc;
    logic              commit;

    always_comb begin
        cond_sc = {meas.cond, 4'b0000} & {SC_W{1'b1}};
        per_sc  = SC_W'(meas.per) * SC_W'(FULL_NUM);
        vd.ok   = 1'b0;
        vd.kind = SW_LEAD;
        if (meas.per != '0) begin
            if (meas.rise >= FRAC_IN_W'(STEEP_THR)) begin
                vd.ok = 1'b1; vd.kind = SW_LEAD;
            end else if (meas.fall >= FRAC_IN_W'(STEEP_THR)) begin
                vd.ok = 1'b1; vd.kind = SW_TRAIL;
            end else if (meas.cond != '0 && cond_sc >= per_sc) begin
                vd.ok = 1'b1; vd.kind = SW_NONE;
            end
        end
        run_len = (streak_q != '0 && vd.kind == cand_q) ? streak_q + 1'b1 : STRK_W'(1);
        commit  = hc_end && learn_q && vd.ok && (run_len == STRK_W'(CONFIRM_N));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode     <= SW_LEAD;
            mode_vld <= 1'b0;
            learn_q  <= 1'b1;
            cand_q   <= SW_LEAD;
            streak_q <= '0;
            idle_q   <= '0;
        end else if (hc_end) begin
            if (learn_q) begin
                if (commit) begin
                    mode     <= vd.kind;
                    mode_vld <= 1'b1;
                    learn_q  <= 1'b0;
                    streak_q <= '0;
                    idle_q   <= '0;
                end else if (!vd.ok) begin
                    streak_q <= '0;
                end else begin
                    cand_q   <= vd.kind;
                    streak_q <= run_len;
                end
            end else if (idle_q + 1'b1 == IDLE_W'(RELEARN_HC)) begin
                learn_q  <= 1'b1;
                streak_q <= '0;
                idle_q   <= '0;
            end else begin
                idle_q <= idle_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/dc_angle_reg.sv
module dc_angle_reg
    import dimclass_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             hc_end,
    input  hc_meas_t         meas,
    output logic [ANG_W-1:0] angle
);

    always_ff @(posedge clk) begin
        if (rst)         angle <= '0;
        else if (hc_end) angle <= angle_frac(meas.cond, meas.per);
    end

endmodule

// File: rtl/dimmer_classifier.sv
module dimmer_classifier
    import dimclass_pkg::*;
#(
    parameter int SMP_W      = 10,
    parameter int CNT_W      = 12,
    parameter int ZERO_THR   = 16,
    parameter int STEEP_THR  = 200,
    parameter int FULL_NUM   = 14,
    parameter int CONFIRM_N  = 4,
    parameter int RELEARN_HC = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             line_vld,
    input  logic [SMP_W-1:0] line_smp,
    input  logic             zc_stb,
    output logic [1:0]       mode,
    output logic             mode_vld,
    output logic [7:0]       cond_angle
);

    hc_meas_t meas;
    sw_mode_e mode_e;

    dc_edge_meter #(.SMP_W(SMP_W), .CNT_W(CNT_W), .ZERO_THR(ZERO_THR)) u_meter (
        .clk(clk), .rst(rst), .smp_vld(line_vld), .smp(line_smp),
        .hc_end(zc_stb), .meas(meas)
    );

    dc_mode_filter #(.STEEP_THR(STEEP_THR), .FULL_NUM(FULL_NUM),
                     .CONFIRM_N(CONFIRM_N), .RELEARN_HC(RELEARN_HC)) u_filter (
        .clk(clk), .rst(rst), .hc_end(zc_stb), .meas(meas),
        .mode(mode_e), .mode_vld(mode_vld)
    );

    dc_angle_reg u_angle (
        .clk(clk), .rst(rst), .hc_end(zc_stb), .meas(meas), .angle(cond_angle)
    );

    assign mode = mode_e;

endmodule

// File: rtl/dimmer_classifier_chk.sv
module dimmer_classifier_chk (
    input logic       clk,
    input logic       rst,
    input logic       zc_stb,
    input logic [1:0] mode,
    input logic       mode_vld,
    input logic [7:0] cond_angle
);

    // R1
    mode_code_legal_chk: assert property (@(posedge clk) disable iff (rst)
        mode != 2'b11);

    // R2
    lead_until_valid_chk: assert property (@(posedge clk) disable iff (rst)
        !mode_vld |-> mode == 2'b01);

    // R2
    valid_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        mode_vld |=> mode_vld);

    // R10
    mode_moves_on_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(mode) |-> ($past(zc_stb) || $past(rst)));

    // R10
    angle_moves_on_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(cond_angle) |-> ($past(zc_stb) || $past(rst)));

    // R10
    valid_rises_on_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mode_vld) |-> $past(zc_stb));

endmodule

bind dimmer_classifier dimmer_classifier_chk u_chk (
    .clk(clk), .rst(rst), .zc_stb(zc_stb),
    .mode(mode), .mode_vld(mode_vld), .cond_angle(cond_angle)
);

// File: tb/dimmer_classifier_tb.sv
module dimmer_classifier_tb;

    localparam int HC_N = 32;
    localparam int ZTHR = 16;

    // waveform kinds
    localparam int K_FULL  = 0;
    localparam int K_LEAD  = 1;
    localparam int K_TRAIL = 2;
    localparam int K_OFF   = 3;
    localparam int K_BOTH  = 4;
    localparam int K_FLAT  = 5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       line_vld = 1'b0;
    logic [9:0] line_smp = '0;
    logic       zc_stb = 1'b0;
    logic [1:0] mode;
    logic       mode_vld;
    logic [7:0] cond_angle;

    int n_chk = 0;
    int n_bad = 0;
    int exp_ang = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dimmer_classifier u_dut (
        .clk(clk), .rst(rst), .line_vld(line_vld), .line_smp(line_smp),
        .zc_stb(zc_stb), .mode(mode), .mode_vld(mode_vld), .cond_angle(cond_angle)
    );

    task automatic check(input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    function automatic int wave(input int kind, input int i);
        int par;
        par = i * (HC_N - i) * 3;
        case (kind)
            K_FULL:  return par;
            K_LEAD:  return (i < 8) ? 0 : par;
            K_TRAIL: return (i < 24) ? par : 0;
            K_OFF:   return 0;
            K_BOTH:  return (i >= 8 && i < 24) ? par : 0;
            default: return 500;
        endcase
    endfunction

    // one half cycle of samples followed by a strobe; outputs sampled after it
    task automatic half_cycle(input int kind);
        int cnt;
        cnt = 0;
        for (int i = 0; i < HC_N; i++) begin
            line_vld = 1'b1;
            line_smp = 10'(wave(kind, i));
            if (wave(kind, i) > ZTHR) cnt++;
            @(negedge clk);
        end
        line_vld = 1'b0;
        zc_stb   = 1'b1;
        @(negedge clk);
        zc_stb   = 1'b0;
        exp_ang  = (cnt * 256) / HC_N;
        if (exp_ang > 255) exp_ang = 255;
    endtask

    task automatic t_reset_state();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R2 reset mode", mode, 1);
        check("R2 reset valid", mode_vld, 0);
        check("R2 reset angle", cond_angle, 0);
        rst = 1'b0;
        @(negedge clk);
        zc_stb = 1'b1;
        @(negedge clk);
        zc_stb = 1'b0;
        check("R9 zero period angle", cond_angle, 0);
        check("R6 empty half cycle no commit", mode_vld, 0);
    endtask

    task automatic t_first_commit();
        for (int j = 1; j <= 3; j++) begin
            half_cycle(K_FULL);
            check("R7 before confirm mode", mode, 1);
            check("R2 before confirm valid", mode_vld, 0);
        end
        half_cycle(K_FULL);
        check("R5 no-dimmer commit", mode, 0);
        check("R2 valid after commit", mode_vld, 1);
        check("R9 full sine angle", cond_angle, exp_ang);
    endtask

    task automatic t_relearn_window();
        for (int j = 1; j <= 68; j++) begin
            half_cycle(K_LEAD);
            if (j == 1)  check("R9 leading angle", cond_angle, exp_ang);
            if (j == 63 || j == 64 || j == 67) check("R8 mode held", mode, 0);
            if (j == 68) check("R3 leading commit after relearn", mode, 1);
        end
        check("R2 valid stays", mode_vld, 1);
    endtask

    task automatic t_noise_break();
        for (int j = 1; j <= 64; j++) half_cycle(K_LEAD);
        half_cycle(K_TRAIL); half_cycle(K_TRAIL); half_cycle(K_TRAIL);
        half_cycle(K_LEAD);
        half_cycle(K_TRAIL); half_cycle(K_TRAIL); half_cycle(K_TRAIL);
        check("R7 interrupted run holds", mode, 1);
        half_cycle(K_TRAIL);
        check("R4 trailing commit", mode, 2);
        check("R9 trailing angle", cond_angle, exp_ang);
    endtask

    task automatic t_dead_half_cycle();
        for (int j = 1; j <= 64; j++) half_cycle(K_TRAIL);
        half_cycle(K_FULL); half_cycle(K_FULL); half_cycle(K_FULL);
        half_cycle(K_OFF);
        check("R9 dead half cycle angle", cond_angle, 0);
        half_cycle(K_FULL); half_cycle(K_FULL); half_cycle(K_FULL);
        check("R6 dead half cycle breaks run", mode, 2);
        half_cycle(K_FULL);
        check("R5 no-dimmer commit after break", mode, 0);
        check("R1 code legal", (mode == 2'b11) ? 1 : 0, 0);
    endtask

    task automatic t_both_edges();
        for (int j = 1; j <= 64; j++) half_cycle(K_FULL);
        for (int j = 1; j <= 4; j++) half_cycle(K_BOTH);
        check("R3 both edges pick leading", mode, 1);
        check("R9 narrow window angle", cond_angle, exp_ang);
    endtask

    task automatic t_full_conduction();
        half_cycle(K_FLAT);
        check("R9 saturated angle", cond_angle, 255);
        check("R8 idle mode unaffected", mode, 1);
    endtask

    task automatic t_reset_midrun();
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R2 mid-run reset mode", mode, 1);
        check("R2 mid-run reset valid", mode_vld, 0);
        check("R2 mid-run reset angle", cond_angle, 0);
    endtask

    initial begin
        t_reset_state();
        t_first_commit();
        t_relearn_window();
        t_noise_break();
        t_dead_half_cycle();
        t_both_edges();
        t_full_conduction();
        t_reset_midrun();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule